// File: doc/BRIEF.md
# Camera Start-Up Sequencer

This block orders the power-on bring-up of a camera controller. Coming out of reset it asks an external DAC engine to write the factory default reference voltages, then asks a flash reader for the header page that locates the stored start-up data. Next it lets the image sensor out of reset, so the sensor can run its self-calibration and settle, and waits a set number of cycles. If the header points at a usable region of flash, the sequencer asks an external loader to configure the secondary FPGA from flash and then has the DAC engine reload the reference voltages from flash. It waits a settling interval and then pulls the sensor reset low for exactly two cycles, which makes the sensor recalibrate against the new voltages. If the header is unusable, the sequencer skips the configuration load and the DAC reload and goes straight to the settling wait and the recalibration pulse.

Each external step is a handshake: the sequencer raises a one-cycle request and waits, with no timeout, for a one-cycle done pulse from that engine. The header offset and length are sampled in the cycle the flash reader signals done. Every timed wait uses one shared down-counter loaded with a parameter. When bring-up is finished the block raises `init_done`. From then on the sensor is recalibrated only when the host asks for it. A host request that arrives before `init_done` is held and served once bring-up is complete. These are plain control pins with no data stream, so there is no back-pressure anywhere on the block.

Top module: `bringup_seq`

## Requirements
- R1: While `rst_n` is low, `sensor_rst_n`, `init_done` and all four request outputs are 0.
- R2: The request outputs are one-cycle pulses and at most one is high in any cycle. The default-DAC request comes first. The header request follows only after `dac_done`.
- R3: `sensor_rst_n` goes high in the cycle after `hdr_done`. With a valid header, it stays high for exactly STAB_CYC cycles before `cfg_req` pulses.
- R4: The header is valid when the offset is nonzero and offset + length, computed without wrap-around, is at most FLASH_SIZE. With a valid header the request order is default DAC, header, configuration load, then the flash DAC load (`dac_load_req`, issued after `cfg_done`).
- R5: With an invalid header, neither `cfg_req` nor `dac_load_req` is ever raised. After the STAB_CYC wait, the sensor stays released for a further SETTLE_CYC cycles and then the recalibration pulse begins.
- R6: After the `dac_done` that ends the flash DAC load, `sensor_rst_n` stays high for exactly SETTLE_CYC cycles. It then goes low for exactly two cycles and comes back high.
- R7: `init_done` first goes high in the same cycle that `sensor_rst_n` returns high after the bring-up pulse. It then stays high until reset.
- R8: After `init_done`, a `host_cal_req` pulse in cycle c drives `sensor_rst_n` low in cycles c+2 and c+3 only.
- R9: Host requests made before `init_done` are merged into a single pending request. That request produces one two-cycle pulse, which starts the cycle after `init_done` rises.
- R10: After `init_done`, with no host request, `sensor_rst_n` stays high.
- R11: A host request made during a host-driven pulse causes one more two-cycle pulse after a single cycle with the sensor released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dac_dflt_req | output | 1 | One-cycle request: write factory default DAC values |
| dac_load_req | output | 1 | One-cycle request: load DAC values from flash |
| dac_done | input | 1 | One-cycle completion pulse from the DAC engine |
| hdr_req | output | 1 | One-cycle request: read the flash header page |
| hdr_done | input | 1 | One-cycle completion pulse from the flash reader |
| hdr_offset | input | ADDR_W | Configuration image offset, sampled with `hdr_done` |
| hdr_length | input | ADDR_W | Configuration image length, sampled with `hdr_done` |
| cfg_req | output | 1 | One-cycle request: load the secondary FPGA from flash |
| cfg_done | input | 1 | One-cycle completion pulse from the FPGA loader |
| host_cal_req | input | 1 | Host request to reset and recalibrate the sensor |
| sensor_rst_n | output | 1 | Active-low reset to the image sensor |
| init_done | output | 1 | High once bring-up has finished |

## Verification
The bench sweeps every header offset of a small configuration, pairing each offset with lengths whose sum lands just below, exactly on and just above the flash size, with a zero length, and with a length large enough to wrap a narrow adder. A validity check that used a wrapped sum, or that missed the equal-to-size edge, would then start a configuration load it should have skipped, or skip one it should have started. Each run also measures the released time before the configuration load and before the recalibration pulse, and the pulse width. An off-by-one in the shared down-counter shows up as a gap that is one cycle too long or too short. Host requests are raised during bring-up, after it, and in the middle of a pulse. A design that let its own bring-up pulse use up the pending request would show no extra pulse. A design that ignored a request made mid-pulse would show only one pulse.

// File: rtl/bringup_pkg.sv
package bringup_pkg;

  localparam int unsigned RECAL_PULSE_CYC = 2;

  typedef enum logic [3:0] {
    ST_BOOT,
    ST_DDAC_REQ,
    ST_DDAC_WAIT,
    ST_HDR_REQ,
    ST_HDR_WAIT,
    ST_STAB,
    ST_CFG_REQ,
    ST_CFG_WAIT,
    ST_RDAC_REQ,
    ST_RDAC_WAIT,
    ST_SETTLE,
    ST_CALP,
    ST_READY
  } seq_state_e;

  // States in which the image sensor is held in reset.
  function automatic logic holds_sensor(seq_state_e s);
    return (s == ST_BOOT)     || (s == ST_DDAC_REQ) || (s == ST_DDAC_WAIT) ||
           (s == ST_HDR_REQ)  || (s == ST_HDR_WAIT) || (s == ST_CALP);
  endfunction

endpackage

// File: rtl/bringup_timer.sv
module bringup_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  // A wait loaded with N ends after N cycles in the waiting state.
  assign last = (cnt_q == W'(1));

endmodule

// File: rtl/bringup_hdr_check.sv
module bringup_hdr_check #(
  parameter int ADDR_W     = 16,
  parameter int FLASH_SIZE = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] offset,
  input  logic [ADDR_W-1:0] length,
  output logic              hdr_ok
);

  localparam int SUM_W = ADDR_W + 1;
  localparam logic [SUM_W-1:0] LIMIT = SUM_W'(FLASH_SIZE);

  logic [SUM_W-1:0] end_addr;
  logic             ok_c;
  logic             ok_q;

  // One extra bit so the end address cannot wrap back into range.
  assign end_addr = {1'b0, offset} + {1'b0, length};
  assign ok_c     = (offset != '0) && (end_addr <= LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n)       ok_q <= 1'b0;
    else if (capture) ok_q <= ok_c;
  end

  assign hdr_ok = ok_q;

endmodule

// File: rtl/bringup_cal_pend.sv
module bringup_cal_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic take,
  output logic pending
);

  logic pend_q;

  // A new request wins over a take in the same cycle, so it gets a later pulse.
  always_ff @(posedge clk) begin
    if (!rst_n)    pend_q <= 1'b0;
    else if (req)  pend_q <= 1'b1;
    else if (take) pend_q <= 1'b0;
  end

  assign pending = pend_q;

endmodule

// File: rtl/bringup_fsm.sv
module bringup_fsm
  import bringup_pkg::*;
#(
  parameter int TMR_W      = 4,
  parameter int STAB_CYC   = 5,
  parameter int SETTLE_CYC = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dac_done,
  input  logic             hdr_done,
  input  logic             cfg_done,
  input  logic             hdr_ok,
  input  logic             tmr_last,
  input  logic             cal_pend,
  output logic             dac_dflt_req,
  output logic             dac_load_req,
  output logic             hdr_req,
  output logic             cfg_req,
  output logic             hdr_cap,
  output logic             tmr_load,
  output logic [TMR_W-1:0] tmr_val,
  output logic             cal_take,
  output logic             sensor_rst_n,
  output logic             init_done
);

  localparam logic [TMR_W-1:0] STAB_V   = TMR_W'(STAB_CYC);
  localparam logic [TMR_W-1:0] SETTLE_V = TMR_W'(SETTLE_CYC);
  localparam logic [TMR_W-1:0] PULSE_V  = TMR_W'(RECAL_PULSE_CYC);

  seq_state_e state_q, nxt;
  logic       srst_n_q;
  logic       done_q;

  always_comb begin
    nxt          = state_q;
    dac_dflt_req = 1'b0;
    dac_load_req = 1'b0;
    hdr_req      = 1'b0;
    cfg_req      = 1'b0;
    hdr_cap      = 1'b0;
    tmr_load     = 1'b0;
    tmr_val      = '0;
    cal_take     = 1'b0;
    unique case (state_q)
      ST_BOOT: nxt = ST_DDAC_REQ;
      ST_DDAC_REQ: begin
        dac_dflt_req = 1'b1;
        nxt          = ST_DDAC_WAIT;
      end
      ST_DDAC_WAIT: if (dac_done) nxt = ST_HDR_REQ;
      ST_HDR_REQ: begin
        hdr_req = 1'b1;
        nxt     = ST_HDR_WAIT;
      end
      ST_HDR_WAIT: begin
        if (hdr_done) begin
          hdr_cap  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = STAB_V;
          nxt      = ST_STAB;
        end
      end
      ST_STAB: begin
        if (tmr_last) begin
          if (hdr_ok) begin
            nxt = ST_CFG_REQ;
          end else begin
            tmr_load = 1'b1;
            tmr_val  = SETTLE_V;
            nxt      = ST_SETTLE;
          end
        end
      end
      ST_CFG_REQ: begin
        cfg_req = 1'b1;
        nxt     = ST_CFG_WAIT;
      end
      ST_CFG_WAIT: if (cfg_done) nxt = ST_RDAC_REQ;
      ST_RDAC_REQ: begin
        dac_load_req = 1'b1;
        nxt          = ST_RDAC_WAIT;
      end
      ST_RDAC_WAIT: begin
        if (dac_done) begin
          tmr_load = 1'b1;
          tmr_val  = SETTLE_V;
          nxt      = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (tmr_last) begin
          tmr_load = 1'b1;
          tmr_val  = PULSE_V;
          nxt      = ST_CALP;
        end
      end
      ST_CALP: if (tmr_last) nxt = ST_READY;
      ST_READY: begin
        if (cal_pend) begin
          cal_take = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = PULSE_V;
          nxt      = ST_CALP;
        end
      end
      default: nxt = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_BOOT;
      srst_n_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= nxt;
      srst_n_q <= !holds_sensor(nxt);
      if (state_q == ST_CALP && tmr_last) done_q <= 1'b1;
    end
  end

  assign sensor_rst_n = srst_n_q;
  assign init_done    = done_q;

endmodule

// File: rtl/bringup_seq.sv
module bringup_seq #(
  parameter int ADDR_W     = 16,
  parameter int FLASH_SIZE = 1 << ADDR_W,
  parameter int STAB_CYC   = 1000,
  parameter int SETTLE_CYC = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              dac_dflt_req,
  output logic              dac_load_req,
  input  logic              dac_done,
  output logic              hdr_req,
  input  logic              hdr_done,
  input  logic [ADDR_W-1:0] hdr_offset,
  input  logic [ADDR_W-1:0] hdr_length,
  output logic              cfg_req,
  input  logic              cfg_done,
  input  logic              host_cal_req,
  output logic              sensor_rst_n,
  output logic              init_done
);

  localparam int WAIT_MAX0 = (STAB_CYC > SETTLE_CYC) ? STAB_CYC : SETTLE_CYC;
  localparam int WAIT_MAX  = (WAIT_MAX0 > int'(bringup_pkg::RECAL_PULSE_CYC)) ?
                             WAIT_MAX0 : int'(bringup_pkg::RECAL_PULSE_CYC);
  localparam int TMR_W     = $clog2(WAIT_MAX + 1);

  logic             hdr_cap;
  logic             hdr_ok;
  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_last;
  logic             cal_pend;
  logic             cal_take;

  bringup_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  bringup_hdr_check #(.ADDR_W(ADDR_W), .FLASH_SIZE(FLASH_SIZE)) u_hdr (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (hdr_cap),
    .offset  (hdr_offset),
    .length  (hdr_length),
    .hdr_ok  (hdr_ok)
  );

  bringup_cal_pend u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (host_cal_req),
    .take    (cal_take),
    .pending (cal_pend)
  );

  bringup_fsm #(
    .TMR_W      (TMR_W),
    .STAB_CYC   (STAB_CYC),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .dac_done     (dac_done),
    .hdr_done     (hdr_done),
    .cfg_done     (cfg_done),
    .hdr_ok       (hdr_ok),
    .tmr_last     (tmr_last),
    .cal_pend     (cal_pend),
    .dac_dflt_req (dac_dflt_req),
    .dac_load_req (dac_load_req),
    .hdr_req      (hdr_req),
    .cfg_req      (cfg_req),
    .hdr_cap      (hdr_cap),
    .tmr_load     (tmr_load),
    .tmr_val      (tmr_val),
    .cal_take     (cal_take),
    .sensor_rst_n (sensor_rst_n),
    .init_done    (init_done)
  );

endmodule

// File: rtl/bringup_seq_chk.sv
module bringup_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic dac_dflt_req,
  input logic dac_load_req,
  input logic hdr_req,
  input logic cfg_req,
  input logic sensor_rst_n,
  input logic init_done
);

  logic any_req;
  assign any_req = dac_dflt_req | dac_load_req | hdr_req | cfg_req;

  // R2
  req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dac_dflt_req, dac_load_req, hdr_req, cfg_req}));

  // R2
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> !any_req);

  // R2
  dflt_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_dflt_req |-> (!init_done && !sensor_rst_n));

  // R3
  cfg_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> sensor_rst_n);

  // R6
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sensor_rst_n) |=> !sensor_rst_n ##1 sensor_rst_n);

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

endmodule

bind bringup_seq bringup_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dac_dflt_req (dac_dflt_req),
  .dac_load_req (dac_load_req),
  .hdr_req      (hdr_req),
  .cfg_req      (cfg_req),
  .sensor_rst_n (sensor_rst_n),
  .init_done    (init_done)
);

// File: tb/bringup_seq_bench.sv
module bringup_seq_bench;

  localparam int AW     = 6;
  localparam int FS     = 48;
  localparam int STAB   = 5;
  localparam int SETTLE = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dac_dflt_req, dac_load_req, hdr_req, cfg_req;
  logic          dac_done = 1'b0, hdr_done = 1'b0, cfg_done = 1'b0;
  logic [AW-1:0] hdr_offset = '0, hdr_length = '0;
  logic          host_cal_req = 1'b0;
  logic          sensor_rst_n, init_done;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  bringup_seq #(
    .ADDR_W(AW), .FLASH_SIZE(FS), .STAB_CYC(STAB), .SETTLE_CYC(SETTLE)
  ) u_bringup_seq (
    .clk(clk), .rst_n(rst_n),
    .dac_dflt_req(dac_dflt_req), .dac_load_req(dac_load_req), .dac_done(dac_done),
    .hdr_req(hdr_req), .hdr_done(hdr_done),
    .hdr_offset(hdr_offset), .hdr_length(hdr_length),
    .cfg_req(cfg_req), .cfg_done(cfg_done),
    .host_cal_req(host_cal_req),
    .sensor_rst_n(sensor_rst_n), .init_done(init_done)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; host_cal_req = 1'b0;
    dac_done = 1'b0; hdr_done = 1'b0; cfg_done = 1'b0;
    repeat (3) @(negedge clk);
    // R1: everything quiet while reset is held
    check_eq("R1", {27'd0, sensor_rst_n, init_done, dac_dflt_req | dac_load_req, hdr_req, cfg_req}, 0);
    rst_n = 1'b1;
  endtask

  task automatic run_init(input int off, input int len, input bit early);
    int order = 0, resp = 0, rk = 0, gap = 0;
    int cfg_gap = -1, fall_gap = -1, nf = 0, nr = 0, init_cyc = -1;
    int falls[4] = '{-100, -100, -100, -100};
    int rises[4] = '{-100, -100, -100, -100};
    bit prev_rst = 1'b0, prev_done = 1'b0, raised, anyreq;
    bit exp_ok = (off != 0) && (off + len <= FS);
    hdr_offset = AW'(off);
    hdr_length = AW'(len);
    do_reset();
    for (int cyc = 0; cyc < 600; cyc++) begin
      @(negedge clk);
      dac_done = 1'b0; hdr_done = 1'b0; cfg_done = 1'b0;
      host_cal_req = early && (cyc == 3 || cyc == 6);
      raised = 1'b0;
      if (resp > 0) begin
        resp--;
        if (resp == 0) begin
          raised = 1'b1;
          case (rk)
            1, 4:    dac_done = 1'b1;
            2:       hdr_done = 1'b1;
            default: cfg_done = 1'b1;
          endcase
        end
      end
      anyreq = dac_dflt_req | hdr_req | cfg_req | dac_load_req;
      if (dac_dflt_req) begin order = order * 8 + 1; resp = 2; rk = 1; end
      if (hdr_req)      begin order = order * 8 + 2; resp = 2; rk = 2; end
      if (cfg_req)      begin order = order * 8 + 3; resp = 2; rk = 3; cfg_gap = gap; end
      if (dac_load_req) begin order = order * 8 + 4; resp = 2; rk = 4; end
      if (raised) gap = 0;
      else if (sensor_rst_n && !anyreq) gap++;
      if (prev_rst && !sensor_rst_n) begin
        if (nf == 0) fall_gap = gap;
        if (nf < 4) falls[nf] = cyc;
        nf++;
      end
      if (!prev_rst && sensor_rst_n && nf > 0) begin
        if (nr < 4) rises[nr] = cyc;
        nr++;
      end
      if (init_done && !prev_done) init_cyc = cyc;
      prev_rst  = sensor_rst_n;
      prev_done = init_done;
      if (init_cyc >= 0 && cyc >= init_cyc + 10) break;
    end
    host_cal_req = 1'b0;
    if (exp_ok) begin
      check_eq("R4", order, 668);       // dflt, header, cfg, flash DAC
      check_eq("R3", cfg_gap, STAB);
      check_eq("R6", fall_gap, SETTLE);
    end else begin
      check_eq("R5", order, 10);        // dflt, header only
      check_eq("R5", fall_gap, STAB + SETTLE);
    end
    check_eq("R6", rises[0] - falls[0], 2);
    check_eq("R7", init_cyc, rises[0]);
    if (early) begin
      check_eq("R9", nf, 2);
      check_eq("R9", falls[1], rises[0] + 1);
      check_eq("R9", rises[1] - falls[1], 2);
    end else begin
      check_eq("R10", nf, 1);
    end
  endtask

  task automatic cal_probe(input bit second);
    int lowmask = 0, done_lost = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      host_cal_req = (k == 0) || (second && k == 2);
      if (!sensor_rst_n) lowmask |= (1 << k);
      if (!init_done) done_lost++;
    end
    host_cal_req = 1'b0;
    if (second) check_eq("R11", lowmask, 12 | 96);
    else        check_eq("R8", lowmask, 12);
    check_eq("R7", done_lost, 0);
    lowmask = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (!sensor_rst_n) lowmask |= (1 << k);
    end
    check_eq("R10", lowmask, 0);
  endtask

  initial begin
    int lens[5];
    for (int off = 0; off < 64; off++) begin
      lens = '{0, FS - off - 1, FS - off, FS - off + 1, 63};
      for (int li = 0; li < 5; li++) begin
        if (lens[li] < 0 || lens[li] > 63) continue;
        run_init(off, lens[li], (off % 4 == 0) && (li == 2));
        if (off % 8 == 1) cal_probe(off % 16 == 1);
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule